// File: doc/BRIEF.md
# Interconnect Error Capture Unit

This unit sits next to a coherent interconnect and watches two error events: an access that matches no local address window, and a coherency violation. Each event comes with the ID of the requester, the failing address (up to 40 bits) and a 5-bit capture type. The unit sets a sticky detect bit for each event it sees. It keeps the details of the first error in a set of capture registers and drives a registered, level-sensitive interrupt.

Software reads and writes the unit through a plain 32-bit register port, with a write strobe, a word offset and a combinational read. Detect bits are cleared by writing 1 to them, so software can read the detect word and write the same value back. A parameter selects one of two register layouts. In the enable layout (MODE 0), the control word turns detection and interrupts on together, and the capture-valid flag sits in the attribute word. In the disable layout (MODE 1), the control word masks detection, a separate word gates interrupts, and the capture-valid flag and capture type sit in the detect word.

Top module: `icx_err_capture`

## Requirements
- R1: After reset, every mapped offset (0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18) reads zero and irq_o is low.
- R2: Event acceptance is gated by the control word at offset 0x04. In MODE 0 an event is recorded only when its control bit is 1. In MODE 1 an event is recorded only when its control bit is 0.
- R3: In the detect word at offset 0x00, bit 0 is the address-window miss and bit 1 is the coherency violation. An accepted event sets its bit on the clock edge that samples it. The bit stays set until it is cleared.
- R4: The capture registers load on an accepted event only when no valid capture is pending. Later events while a capture is pending set only their detect bits.
- R5: In MODE 1, detect bit 31 reads the capture-valid flag and bits 30:26 read the captured type; both read zero while no capture is valid. Attribute word 0x0C carries the source ID in bits 25:18.
- R6: In MODE 0, attribute word 0x0C carries capture-valid in bit 0, the unavailable-target flag in bit 15 and the source ID in bits 31:24.
- R7: Offset 0x10 returns captured address bits 39:32 in bits 7:0, with the upper bits zero. Offset 0x14 returns address bits 31:0. Offset 0x18 returns the captured type in bits 4:0.
- R8: A write to offset 0x00 clears each detect bit written as 1 and leaves bits written as 0 unchanged. Any 1 written to bits 1:0 also clears the capture-valid flag, so writing back the value just read clears the serviced errors.
- R9: When an event and a clear of the same detect bit fall in one cycle, the bit ends up set. If that clear also drops the capture-valid flag, the new event is captured.
- R10: irq_o is a registered signal. One cycle after the detect bits change, it equals the OR of the detect bits ANDed with the interrupt gate. The gate is the control word in MODE 0 and the interrupt-enable word at 0x08 in MODE 1.
- R11: In MODE 0, offset 0x08 always reads zero and writes to it have no effect. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_law_i | input | 1 | Address-window miss event, one cycle per error |
| evt_coh_i | input | 1 | Coherency violation event, one cycle per error |
| evt_src_i | input | SRC_W | Requester ID of the event |
| evt_addr_i | input | ADDR_W | Failing address |
| evt_type_i | input | TYPE_W | Capture type code |
| evt_uvt_i | input | 1 | Target ID unavailable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A software clear of a detect bit and a new event on that same bit can fall in the same cycle. When they do, the detect bit must win, and the capture-valid flag must drop and come back with the new event's details. The bench provokes this by asserting the write strobe to offset 0x00 and the event input on one falling edge while an earlier capture is still pending. It then reads the detect word and the attribute and address words, and expects the detect bit still set, valid set, and the second event's source ID, type and address in place of the first.

// File: rtl/icx_err_pkg.sv
package icx_err_pkg;
   // number of event classes and their bit positions in detect/control words
   localparam int NUM_EV   = 2;
   localparam int EV_LAW   = 0;
   localparam int EV_COH   = 1;

   // register byte offsets
   localparam int OFF_DET   = 'h00;
   localparam int OFF_CTL   = 'h04;
   localparam int OFF_IEN   = 'h08;
   localparam int OFF_ATTR  = 'h0C;
   localparam int OFF_AHI   = 'h10;
   localparam int OFF_ALO   = 'h14;
   localparam int OFF_ATTR2 = 'h18;

   // field positions decoded by software
   localparam int DET_VLD_BIT  = 31;
   localparam int DET_TYPE_LSB = 26;
   localparam int M0_VLD_BIT   = 0;
   localparam int M0_UVT_BIT   = 15;
   localparam int M0_SRC_LSB   = 24;
   localparam int M1_SRC_LSB   = 18;

   // upper limits of the field widths
   localparam int SRC_MAX  = 8;
   localparam int TYPE_MAX = 5;
   localparam int ADDR_MAX = 40;
endpackage

// File: rtl/icx_err_cfg.sv
module icx_err_cfg
   import icx_err_pkg::*;
#(
   parameter int MODE   = 1,
   parameter int REG_AW = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [NUM_EV-1:0] wbits_i,
   output logic [NUM_EV-1:0] ctl_o,
   output logic [NUM_EV-1:0] ien_o,
   output logic [NUM_EV-1:0] det_act_o,
   output logic [NUM_EV-1:0] irq_gate_o
);
   localparam logic [REG_AW-1:0] A_CTL = REG_AW'(OFF_CTL);
   localparam logic [REG_AW-1:0] A_IEN = REG_AW'(OFF_IEN);

   logic [NUM_EV-1:0] ctl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ctl_q <= '0;
      else if (we_i && addr_i == A_CTL) ctl_q <= wbits_i;
   end
   assign ctl_o = ctl_q;

   generate
      if (MODE == 0) begin : g_enable
         // control word enables detection and interrupts together
         assign ien_o      = '0;
         assign det_act_o  = ctl_q;
         assign irq_gate_o = ctl_q;
      end else begin : g_disable
         logic [NUM_EV-1:0] ien_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                     ien_q <= '0;
            else if (we_i && addr_i == A_IEN) ien_q <= wbits_i;
         end
         assign ien_o      = ien_q;
         assign det_act_o  = ~ctl_q;
         assign irq_gate_o = ien_q;

         // R11
         ien_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(we_i && addr_i == A_IEN) |=> $stable(ien_q));
      end
   endgenerate
endmodule

// File: rtl/icx_err_status.sv
module icx_err_status
   import icx_err_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int SRC_W  = 8,
   parameter int TYPE_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_EV-1:0] ev_i,
   input  logic [SRC_W-1:0]  ev_src_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   input  logic [TYPE_W-1:0] ev_type_i,
   input  logic              ev_uvt_i,
   input  logic [NUM_EV-1:0] det_act_i,
   input  logic              clr_wr_i,
   input  logic [NUM_EV-1:0] clr_bits_i,
   output logic [NUM_EV-1:0] det_o,
   output logic              vld_o,
   output logic [SRC_W-1:0]  cap_src_o,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic [TYPE_W-1:0] cap_type_o,
   output logic              cap_uvt_o
);
   logic [NUM_EV-1:0] det_q, acc, clr_mask;
   logic              vld_q, clr_any, take;
   logic [SRC_W-1:0]  src_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TYPE_W-1:0] type_q;
   logic              uvt_q;

   assign acc      = ev_i & det_act_i;
   assign clr_mask = clr_wr_i ? clr_bits_i : '0;
   assign clr_any  = |clr_mask;
   // a clear in the same cycle frees the capture slot for a new event
   assign take     = (|acc) && (!vld_q || clr_any);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         det_q <= '0;
         vld_q <= 1'b0;
      end else begin
         det_q <= (det_q & ~clr_mask) | acc;
         if (take)         vld_q <= 1'b1;
         else if (clr_any) vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q  <= '0;
         addr_q <= '0;
         type_q <= '0;
         uvt_q  <= 1'b0;
      end else if (take) begin
         src_q  <= ev_src_i;
         addr_q <= ev_addr_i;
         type_q <= ev_type_i;
         uvt_q  <= ev_uvt_i;
      end
   end

   assign det_o      = det_q;
   assign vld_o      = vld_q;
   assign cap_src_o  = src_q;
   assign cap_addr_o = addr_q;
   assign cap_type_o = type_q;
   assign cap_uvt_o  = uvt_q;

   // R3
   det_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|acc) |=> ((det_q & $past(acc)) == $past(acc)));
   // R4
   cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q && !clr_any) |=> ($stable(addr_q) && $stable(src_q) && $stable(type_q)));
   // R8
   clr_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_mask & ~acc)) |=> ((det_q & $past(clr_mask & ~acc)) == '0));
   // R8
   clr_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_any && !(|acc)) |=> !vld_q);
   // R9
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_any && (|acc)) |=> vld_q);
endmodule

// File: rtl/icx_err_rdmux.sv
module icx_err_rdmux
   import icx_err_pkg::*;
#(
   parameter int MODE   = 1,
   parameter int REG_AW = 5,
   parameter int ADDR_W = 40,
   parameter int SRC_W  = 8,
   parameter int TYPE_W = 5
) (
   input  logic [REG_AW-1:0] addr_i,
   input  logic [NUM_EV-1:0] det_i,
   input  logic              vld_i,
   input  logic [NUM_EV-1:0] ctl_i,
   input  logic [NUM_EV-1:0] ien_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [ADDR_W-1:0] cap_addr_i,
   input  logic [TYPE_W-1:0] type_i,
   input  logic              uvt_i,
   output logic [31:0]       rdata_o
);
   localparam int HI_W = ADDR_W - 32;

   localparam logic [REG_AW-1:0] A_DET   = REG_AW'(OFF_DET);
   localparam logic [REG_AW-1:0] A_CTL   = REG_AW'(OFF_CTL);
   localparam logic [REG_AW-1:0] A_IEN   = REG_AW'(OFF_IEN);
   localparam logic [REG_AW-1:0] A_ATTR  = REG_AW'(OFF_ATTR);
   localparam logic [REG_AW-1:0] A_AHI   = REG_AW'(OFF_AHI);
   localparam logic [REG_AW-1:0] A_ALO   = REG_AW'(OFF_ALO);
   localparam logic [REG_AW-1:0] A_ATTR2 = REG_AW'(OFF_ATTR2);

   logic [31:0] det_word, attr_word, ien_word;
   logic [7:0]  src8;
   logic [4:0]  type5;

   assign src8  = 8'(src_i);
   assign type5 = 5'(type_i);

   generate
      if (MODE == 0) begin : g_enable
         logic ien_unused;
         assign ien_unused = ^ien_i;
         always_comb begin
            det_word             = '0;
            det_word[NUM_EV-1:0] = det_i;
            attr_word                         = '0;
            attr_word[M0_VLD_BIT]             = vld_i;
            attr_word[M0_UVT_BIT]             = uvt_i;
            attr_word[M0_SRC_LSB +: SRC_MAX]  = src8;
         end
         assign ien_word = '0;
      end else begin : g_disable
         logic uvt_unused;
         assign uvt_unused = uvt_i;
         always_comb begin
            det_word             = '0;
            det_word[NUM_EV-1:0] = det_i;
            det_word[DET_VLD_BIT] = vld_i;
            if (vld_i) det_word[DET_TYPE_LSB +: TYPE_MAX] = type5;
            attr_word                        = '0;
            attr_word[M1_SRC_LSB +: SRC_MAX] = src8;
         end
         assign ien_word = {{(32-NUM_EV){1'b0}}, ien_i};
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_DET:   rdata_o = det_word;
         A_CTL:   rdata_o = {{(32-NUM_EV){1'b0}}, ctl_i};
         A_IEN:   rdata_o = ien_word;
         A_ATTR:  rdata_o = attr_word;
         A_AHI:   rdata_o = {24'b0, 8'(cap_addr_i[ADDR_W-1 -: HI_W])};
         A_ALO:   rdata_o = cap_addr_i[31:0];
         A_ATTR2: rdata_o = {27'b0, type5};
         default: rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/icx_err_capture.sv
module icx_err_capture
   import icx_err_pkg::*;
#(
   parameter int MODE   = 1,
   parameter int REG_AW = 5,
   parameter int ADDR_W = 40,
   parameter int SRC_W  = 8,
   parameter int TYPE_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_law_i,
   input  logic              evt_coh_i,
   input  logic [SRC_W-1:0]  evt_src_i,
   input  logic [ADDR_W-1:0] evt_addr_i,
   input  logic [TYPE_W-1:0] evt_type_i,
   input  logic              evt_uvt_i,
   input  logic              reg_we_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_o
);
   localparam logic [REG_AW-1:0] A_DET = REG_AW'(OFF_DET);

   initial begin
      mode_ok_chk:  assert (MODE == 0 || MODE == 1) else $error("MODE must be 0 or 1");
      addr_ok_chk:  assert (ADDR_W > 32 && ADDR_W <= ADDR_MAX) else $error("ADDR_W out of range");
      src_ok_chk:   assert (SRC_W >= 1 && SRC_W <= SRC_MAX) else $error("SRC_W out of range");
      type_ok_chk:  assert (TYPE_W >= 1 && TYPE_W <= TYPE_MAX) else $error("TYPE_W out of range");
      aw_ok_chk:    assert (REG_AW >= 5) else $error("REG_AW too small for map");
   end

   logic [NUM_EV-1:0] ev, ctl, ien, det_act, irq_gate, det;
   logic              vld, cap_uvt, irq_q;
   logic [SRC_W-1:0]  cap_src;
   logic [ADDR_W-1:0] cap_addr;
   logic [TYPE_W-1:0] cap_type;
   logic              wdata_unused;

   assign wdata_unused = ^reg_wdata_i[31:NUM_EV];

   always_comb begin
      ev         = '0;
      ev[EV_LAW] = evt_law_i;
      ev[EV_COH] = evt_coh_i;
   end

   icx_err_cfg #(.MODE(MODE), .REG_AW(REG_AW)) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (reg_we_i),
      .addr_i     (reg_addr_i),
      .wbits_i    (reg_wdata_i[NUM_EV-1:0]),
      .ctl_o      (ctl),
      .ien_o      (ien),
      .det_act_o  (det_act),
      .irq_gate_o (irq_gate)
   );

   icx_err_status #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .TYPE_W(TYPE_W)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (ev),
      .ev_src_i   (evt_src_i),
      .ev_addr_i  (evt_addr_i),
      .ev_type_i  (evt_type_i),
      .ev_uvt_i   (evt_uvt_i),
      .det_act_i  (det_act),
      .clr_wr_i   (reg_we_i && reg_addr_i == A_DET),
      .clr_bits_i (reg_wdata_i[NUM_EV-1:0]),
      .det_o      (det),
      .vld_o      (vld),
      .cap_src_o  (cap_src),
      .cap_addr_o (cap_addr),
      .cap_type_o (cap_type),
      .cap_uvt_o  (cap_uvt)
   );

   icx_err_rdmux #(
      .MODE(MODE), .REG_AW(REG_AW), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .TYPE_W(TYPE_W)
   ) u_rdmux (
      .addr_i     (reg_addr_i),
      .det_i      (det),
      .vld_i      (vld),
      .ctl_i      (ctl),
      .ien_i      (ien),
      .src_i      (cap_src),
      .cap_addr_i (cap_addr),
      .type_i     (cap_type),
      .uvt_i      (cap_uvt),
      .rdata_o    (reg_rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(det & irq_gate);
   end
   assign irq_o = irq_q;

   // R10
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(det & irq_gate)) |=> irq_o);
   // R10
   irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(det & irq_gate)) |=> !irq_o);
endmodule

// File: tb/icx_err_capture_bench.sv
module icx_err_capture_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        law = 1'b0, coh = 1'b0, uvt = 1'b0;
   logic [7:0]  src = '0;
   logic [39:0] eaddr = '0;
   logic [4:0]  etype = '0;
   logic        we = 1'b0;
   logic [4:0]  raddr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd1, rd0;
   logic        irq1, irq0;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // MODE 1 (disable layout)
   icx_err_capture #(.MODE(1)) u_icx_err_capture (
      .clk_i(clk), .rst_ni(rst_n), .evt_law_i(law), .evt_coh_i(coh),
      .evt_src_i(src), .evt_addr_i(eaddr), .evt_type_i(etype), .evt_uvt_i(uvt),
      .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
      .reg_rdata_o(rd1), .irq_o(irq1));

   // MODE 0 (enable layout)
   icx_err_capture #(.MODE(0)) u_icx_err_capture_m0 (
      .clk_i(clk), .rst_ni(rst_n), .evt_law_i(law), .evt_coh_i(coh),
      .evt_src_i(src), .evt_addr_i(eaddr), .evt_type_i(etype), .evt_uvt_i(uvt),
      .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
      .reg_rdata_o(rd0), .irq_o(irq0));

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; raddr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v1, output logic [31:0] v0);
      raddr = a;
      #1;
      v1 = rd1;
      v0 = rd0;
   endtask

   task automatic pulse(input logic l, input logic c, input logic [7:0] s,
                        input logic [39:0] a, input logic [4:0] t, input logic u);
      @(negedge clk);
      law = l; coh = c; src = s; eaddr = a; etype = t; uvt = u;
      @(negedge clk);
      law = 1'b0; coh = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v1, v0;
      for (int i = 0; i < 7; i++) begin
         rd(5'(i * 4), v1, v0);
         chk("R1", "m1 reg after reset", v1, 32'h0);
         chk("R1", "m0 reg after reset", v0, 32'h0);
      end
      chk("R1", "m1 irq after reset", {31'b0, irq1}, 32'h0);
      chk("R1", "m0 irq after reset", {31'b0, irq0}, 32'h0);
   endtask

   task automatic t_mode1_capture();
      logic [31:0] v1, v0;
      wr(5'h04, 32'h0);
      wr(5'h08, 32'h0);
      pulse(1'b1, 1'b0, 8'hA5, 40'h12_3456_789A, 5'h13, 1'b0);
      rd(5'h00, v1, v0);
      chk("R5", "m1 detect after miss", v1, 32'hCC00_0001);
      chk("R2", "m0 detect with enable off", v0, 32'h0);
      rd(5'h0C, v1, v0);
      chk("R5", "m1 attr src field", v1, 32'h0294_0000);
      rd(5'h10, v1, v0);
      chk("R7", "m1 addr high", v1, 32'h0000_0012);
      rd(5'h14, v1, v0);
      chk("R7", "m1 addr low", v1, 32'h3456_789A);
      rd(5'h18, v1, v0);
      chk("R7", "m1 attr2 type", v1, 32'h0000_0013);
      tick();
      chk("R10", "m1 irq with ien zero", {31'b0, irq1}, 32'h0);
      // second error: only its detect bit
      pulse(1'b0, 1'b1, 8'h3C, 40'h00_0000_0040, 5'h02, 1'b0);
      rd(5'h00, v1, v0);
      chk("R3", "m1 detect both bits", v1, 32'hCC00_0003);
      rd(5'h0C, v1, v0);
      chk("R4", "m1 attr keeps first src", v1, 32'h0294_0000);
      rd(5'h14, v1, v0);
      chk("R4", "m1 addr low keeps first", v1, 32'h3456_789A);
      wr(5'h08, 32'h2);
      tick();
      chk("R10", "m1 irq via coh enable", {31'b0, irq1}, 32'h1);
      wr(5'h08, 32'h1);
      tick();
      chk("R10", "m1 irq via law enable", {31'b0, irq1}, 32'h1);
      wr(5'h00, 32'h1);
      rd(5'h00, v1, v0);
      chk("R8", "m1 detect after w1c bit0", v1, 32'h0000_0002);
      tick();
      chk("R10", "m1 irq drops after clear", {31'b0, irq1}, 32'h0);
      wr(5'h00, 32'h0);
      rd(5'h00, v1, v0);
      chk("R8", "m1 write zero no effect", v1, 32'h0000_0002);
      // mask the miss event in the disable layout
      wr(5'h04, 32'h1);
      pulse(1'b1, 1'b0, 8'h11, 40'h0, 5'h0, 1'b0);
      rd(5'h00, v1, v0);
      chk("R2", "m1 disabled miss ignored", v1, 32'h0000_0002);
      rd(5'h0C, v1, v0);
      chk("R2", "m1 disabled miss no capture", v1, 32'h0294_0000);
      // write back what was read
      rd(5'h00, v1, v0);
      wr(5'h00, v1);
      rd(5'h00, v1, v0);
      chk("R8", "m1 write-back clears", v1, 32'h0);
   endtask

   task automatic t_mode0_capture();
      logic [31:0] v1, v0;
      wr(5'h04, 32'h3);
      wr(5'h00, 32'h3);
      pulse(1'b0, 1'b1, 8'h7E, 40'hFF_0000_0001, 5'h04, 1'b1);
      rd(5'h00, v1, v0);
      chk("R3", "m0 detect coh bit", v0, 32'h0000_0002);
      chk("R2", "m1 detect with disable set", v1, 32'h0);
      rd(5'h0C, v1, v0);
      chk("R6", "m0 attr layout", v0, 32'h7E00_8001);
      rd(5'h10, v1, v0);
      chk("R7", "m0 addr high", v0, 32'h0000_00FF);
      rd(5'h14, v1, v0);
      chk("R7", "m0 addr low", v0, 32'h0000_0001);
      tick();
      chk("R10", "m0 irq from enable", {31'b0, irq0}, 32'h1);
      wr(5'h08, 32'h3);
      rd(5'h08, v1, v0);
      chk("R11", "m0 ien reads zero", v0, 32'h0);
      chk("R11", "m1 ien readback", v1, 32'h3);
      rd(5'h1C, v1, v0);
      chk("R11", "m0 unmapped", v0, 32'h0);
      chk("R11", "m1 unmapped", v1, 32'h0);
      wr(5'h04, 32'h0);
      tick();
      chk("R10", "m0 irq off with enable off", {31'b0, irq0}, 32'h0);
      pulse(1'b1, 1'b0, 8'h22, 40'h0, 5'h0, 1'b0);
      rd(5'h00, v1, v0);
      chk("R2", "m0 miss ignored when disabled", v0, 32'h0000_0002);
      wr(5'h00, 32'h2);
      rd(5'h0C, v1, v0);
      chk("R6", "m0 valid dropped by clear", v0, 32'h7E00_8000);
   endtask

   task automatic t_collide();
      logic [31:0] v1, v0;
      wr(5'h04, 32'h0);
      wr(5'h08, 32'h0);
      wr(5'h00, 32'h3);
      pulse(1'b1, 1'b0, 8'h01, 40'h01_0000_0010, 5'h01, 1'b0);
      // clear and new event on the same edge
      @(negedge clk);
      we = 1'b1; raddr = 5'h00; wdata = 32'h1;
      law = 1'b1; src = 8'h02; eaddr = 40'h02_0000_0020; etype = 5'h02;
      @(negedge clk);
      we = 1'b0; wdata = '0; law = 1'b0;
      rd(5'h00, v1, v0);
      chk("R9", "m1 detect set wins", v1, 32'h8800_0001);
      rd(5'h0C, v1, v0);
      chk("R9", "m1 recapture src", v1, 32'h0008_0000);
      rd(5'h14, v1, v0);
      chk("R9", "m1 recapture addr", v1, 32'h0000_0020);
      // both events at once: one capture, two bits
      wr(5'h00, 32'h3);
      pulse(1'b1, 1'b1, 8'h09, 40'h00_0000_0090, 5'h1F, 1'b0);
      rd(5'h00, v1, v0);
      chk("R3", "m1 simultaneous events", v1, 32'hFC00_0003);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mode1_capture();
      t_mode0_capture();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule